// File: doc/BRIEF.md
# Prescaled Watchdog and Reset Pulse Generator

This block is a watchdog for the control register file of a clock generator. A 5-bit timeout field and a one-bit unit select set the timeout. The unit select chooses which of two externally supplied tick enables decrements the counter: a short base of 150 ms or a long base of 2.5 s. When the countdown runs out, the block raises a sticky timeout status flag. If the watchdog reset path is enabled, it also emits a fixed-length reset pulse.

A second source, with its own enable, requests the same reset pulse when a frequency change has completed. Both sources feed one pulse stretcher, which merges them. A request that arrives while a pulse is already running restarts the pulse length, so no request is lost. The block works in system clock cycles only. The two tick enables are single-cycle strobes from outside, so a bench or a system can scale time freely.

Top module: `wdog_rstgen`

## Requirements
- R1: After synchronous reset, `tmo_sts` and `rst_pulse` are 0 and the counter is idle. Ticks do not time it out until a reload happens (kick, field write or `wd_en` low).
- R2: With `unit_sel`=0 only `tick_short` decrements the counter, and with `unit_sel`=1 only `tick_long` does. The unselected tick has no effect.
- R3: After a reload with field value V, the timeout occurs on the (V+1)-th selected tick. `tmo_sts` reads 1 in the cycle after the clock edge that sampled that tick.
- R4: A `kick`, a `tmo_wr` field write, or `wd_en` held low reloads the counter from `tmo_val`. Counting then restarts from the full value. Ticks are ignored while `wd_en` is low.
- R5: `tmo_sts` stays 1 until a `sts_clr` strobe clears it. If a timeout and `sts_clr` fall in the same cycle, the flag is set.
- R6: With `wd_rst_en`=1 a timeout starts a `rst_pulse` that is high for exactly PULSE_LEN (16) cycles, beginning the cycle after the final tick. With `wd_rst_en`=0 a timeout gives no pulse.
- R7: With `fc_rst_en`=1 a `fc_done` strobe starts a 16-cycle `rst_pulse` the following cycle. With `fc_rst_en`=0 the strobe gives no pulse.
- R8: After a timeout the counter stops. Further ticks produce no new timeout or pulse until a reload re-arms it.
- R9: A pulse request while `rst_pulse` is high restarts the length, so the pulse ends 16 cycles after the latest request.
- R10: Requests from both sources in the same cycle give one pulse of 16 cycles.
- R11: A reload in the same cycle as a selected tick takes priority. The tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_en | input | 1 | Watchdog enable; low holds the counter reloaded |
| kick | input | 1 | Service strobe, reloads the counter |
| tmo_wr | input | 1 | Strobe marking a write of the timeout field |
| tmo_val | input | 5 | Timeout field, ticks to expiry minus one |
| unit_sel | input | 1 | 0: short (150 ms) unit, 1: long (2.5 s) unit |
| tick_short | input | 1 | Single-cycle enable of the short time base |
| tick_long | input | 1 | Single-cycle enable of the long time base |
| wd_rst_en | input | 1 | Enables a reset pulse on timeout |
| fc_rst_en | input | 1 | Enables a reset pulse after a frequency change |
| fc_done | input | 1 | Strobe: a frequency change has completed |
| sts_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| tmo_sts | output | 1 | Sticky timeout status |
| rst_pulse | output | 1 | Reset pulse output |

## Verification
Every result appears one register stage after its cause. The status flag and the start of the pulse both show in the cycle after the edge that sampled the final tick or the `fc_done` strobe. A reload takes effect on the edge that samples it. The bench drives each strobe for one cycle starting at a falling edge and reads the outputs at the next falling edge, which is exactly one rising edge later. It measures pulse lengths by counting consecutive high samples at falling edges, so a change of even one cycle in the stretcher shows up.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned CNT_W_DEF     = 5;
    localparam int unsigned PULSE_LEN_DEF = 16;

    typedef enum logic {
        UNIT_SHORT = 1'b0,
        UNIT_LONG  = 1'b1
    } unit_e;

    // One request bit per reset source
    typedef struct packed {
        logic wdog;
        logic fchg;
    } rst_req_t;

    function automatic logic any_req(input rst_req_t r);
        return r.wdog | r.fchg;
    endfunction

endpackage

// File: rtl/wdt_tick_mux.sv
module wdt_tick_mux
    import wdt_pkg::*;
(
    input  logic unit_sel,
    input  logic tick_short,
    input  logic tick_long,
    output logic tick
);
    unit_e unit;

    always_comb begin
        unit = unit_e'(unit_sel);
        unique case (unit)
            UNIT_SHORT: tick = tick_short;
            UNIT_LONG:  tick = tick_long;
            default:    tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             reload,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    logic armed;

    // The tick that finds the counter at zero is the expiring one
    assign fire = en && armed && tick && (cnt == '0) && !reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (reload) begin
            cnt   <= load_val;
            armed <= 1'b1;
        end else if (fire) begin
            armed <= 1'b0;
        end else if (en && armed && tick) begin
            cnt   <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen
    import wdt_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  rst_req_t req,
    output logic     pulse
);
    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)               remain <= '0;
        else if (any_req(req)) remain <= PW'(PULSE_LEN);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign pulse = (remain != '0);
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W     = CNT_W_DEF,
    parameter int unsigned PULSE_LEN = PULSE_LEN_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wd_en,
    input  logic             kick,
    input  logic             tmo_wr,
    input  logic [CNT_W-1:0] tmo_val,
    input  logic             unit_sel,
    input  logic             tick_short,
    input  logic             tick_long,
    input  logic             wd_rst_en,
    input  logic             fc_rst_en,
    input  logic             fc_done,
    input  logic             sts_clr,
    output logic             tmo_sts,
    output logic             rst_pulse
);
    logic             tick_sel;
    logic             reload;
    logic             tmo_fire;
    logic [CNT_W-1:0] cnt_q;
    rst_req_t         req;

    assign reload = kick | tmo_wr | !wd_en;

    wdt_tick_mux u_mux (
        .unit_sel   (unit_sel),
        .tick_short (tick_short),
        .tick_long  (tick_long),
        .tick       (tick_sel)
    );

    wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (wd_en),
        .reload   (reload),
        .tick     (tick_sel),
        .load_val (tmo_val),
        .cnt      (cnt_q),
        .fire     (tmo_fire)
    );

    wdt_status u_sts (
        .clk  (clk),
        .rst  (rst),
        .set  (tmo_fire),
        .clr  (sts_clr),
        .flag (tmo_sts)
    );

    always_comb begin
        req.wdog = tmo_fire & wd_rst_en;
        req.fchg = fc_done & fc_rst_en;
    end

    wdt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .pulse (rst_pulse)
    );
endmodule

// File: rtl/wdog_rstgen_chk.sv
module wdog_rstgen_chk #(
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned PULSE_LEN = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             reload,
    input logic             tick_sel,
    input logic             tmo_fire,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] tmo_val,
    input logic             wd_rst_en,
    input logic             fc_rst_en,
    input logic             fc_done,
    input logic             sts_clr,
    input logic             tmo_sts,
    input logic             rst_pulse
);
    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    logic          req_any;
    logic [PW-1:0] age;

    assign req_any = (tmo_fire && wd_rst_en) || (fc_done && fc_rst_en);

    // Cycles since the latest pulse request, saturating at PULSE_LEN
    always_ff @(posedge clk) begin
        if (rst)                      age <= PW'(PULSE_LEN);
        else if (req_any)             age <= '0;
        else if (age < PW'(PULSE_LEN)) age <= age + 1'b1;
    end

    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (!reload && !tick_sel) |=> $stable(cnt_q));

    assert_status_source_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_sts) |-> $past(tmo_fire));

    assert_reload_value_R4: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt_q == $past(tmo_val)));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (tmo_sts && !sts_clr) |=> tmo_sts);

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (sts_clr && !tmo_fire) |=> !tmo_sts);

    assert_wd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (tmo_fire && wd_rst_en) |=> rst_pulse);

    assert_fc_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (fc_done && fc_rst_en) |=> rst_pulse);

    assert_single_fire_R8: assert property (@(posedge clk) disable iff (rst)
        tmo_fire |=> !tmo_fire);

    assert_pulse_window_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (rst_pulse == (age < PW'(PULSE_LEN))));

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst_pulse && !req_any) |=> !rst_pulse);
endmodule

bind wdog_rstgen wdog_rstgen_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reload    (reload),
    .tick_sel  (tick_sel),
    .tmo_fire  (tmo_fire),
    .cnt_q     (cnt_q),
    .tmo_val   (tmo_val),
    .wd_rst_en (wd_rst_en),
    .fc_rst_en (fc_rst_en),
    .fc_done   (fc_done),
    .sts_clr   (sts_clr),
    .tmo_sts   (tmo_sts),
    .rst_pulse (rst_pulse)
);

// File: tb/wdog_rstgen_tb_top.sv
`timescale 1ns/1ps
module wdog_rstgen_tb_top;

    localparam int PLEN = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wd_en = 1'b0, kick = 1'b0, tmo_wr = 1'b0;
    logic [4:0] tmo_val = 5'd0;
    logic       unit_sel = 1'b0, tick_short = 1'b0, tick_long = 1'b0;
    logic       wd_rst_en = 1'b0, fc_rst_en = 1'b0, fc_done = 1'b0, sts_clr = 1'b0;
    logic       tmo_sts, rst_pulse;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdog_rstgen dut_i (
        .clk(clk), .rst(rst), .wd_en(wd_en), .kick(kick), .tmo_wr(tmo_wr),
        .tmo_val(tmo_val), .unit_sel(unit_sel), .tick_short(tick_short),
        .tick_long(tick_long), .wd_rst_en(wd_rst_en), .fc_rst_en(fc_rst_en),
        .fc_done(fc_done), .sts_clr(sts_clr), .tmo_sts(tmo_sts), .rst_pulse(rst_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic nxt(); @(negedge clk); endtask

    task automatic do_kick(); kick = 1'b1; nxt(); kick = 1'b0; endtask
    task automatic do_clr();  sts_clr = 1'b1; nxt(); sts_clr = 1'b0; endtask
    task automatic do_fc();   fc_done = 1'b1; nxt(); fc_done = 1'b0; endtask

    task automatic ts(input int n);
        for (int i = 0; i < n; i++) begin nxt(); tick_short = 1'b1; nxt(); tick_short = 1'b0; end
    endtask

    task automatic tl(input int n);
        for (int i = 0; i < n; i++) begin nxt(); tick_long = 1'b1; nxt(); tick_long = 1'b0; end
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (rst_pulse && n < 100) begin n++; nxt(); end
    endtask

    task automatic quiet(input int cyc, output int highs);
        highs = 0;
        for (int i = 0; i < cyc; i++) begin if (rst_pulse) highs++; nxt(); end
    endtask

    task automatic t_reset();
        chk_eq("R1 sts after reset", tmo_sts, 0);
        chk_eq("R1 pulse after reset", rst_pulse, 0);
    endtask

    task automatic t_short_timeout();
        int n;
        wd_en = 1'b1; wd_rst_en = 1'b1; unit_sel = 1'b0;
        tmo_val = 5'd3; tmo_wr = 1'b1; nxt(); tmo_wr = 1'b0;
        ts(3);
        chk_eq("R3 no timeout before V+1 ticks", tmo_sts, 0);
        ts(1);
        chk_eq("R3 timeout on tick V+1", tmo_sts, 1);
        chk_eq("R6 pulse starts", rst_pulse, 1);
        pulse_len(n);
        chk_eq("R6 pulse length", n, PLEN);
        chk_eq("R5 sts sticky", tmo_sts, 1);
        do_clr();
        chk_eq("R5 sts cleared", tmo_sts, 0);
    endtask

    task automatic t_units();
        int h;
        unit_sel = 1'b1; wd_rst_en = 1'b0; tmo_val = 5'd1; do_kick();
        ts(5);
        chk_eq("R2 short tick ignored in long unit", tmo_sts, 0);
        tl(1);
        chk_eq("R3 long unit one tick early", tmo_sts, 0);
        tl(1);
        chk_eq("R3 long unit timeout", tmo_sts, 1);
        quiet(20, h);
        chk_eq("R6 no pulse when disabled", h, 0);
        do_clr();
        unit_sel = 1'b0; tmo_val = 5'd0; do_kick();
        tl(3);
        chk_eq("R2 long tick ignored in short unit", tmo_sts, 0);
        ts(1);
        chk_eq("R2 short unit timeout", tmo_sts, 1);
        do_clr();
    endtask

    task automatic t_reload();
        tmo_val = 5'd2; do_kick();
        ts(2); do_kick(); ts(2);
        chk_eq("R4 kick restarts count", tmo_sts, 0);
        ts(1);
        chk_eq("R4 timeout after kick", tmo_sts, 1);
        do_clr();
        do_kick(); ts(2);
        wd_en = 1'b0; ts(2); wd_en = 1'b1;
        ts(2);
        chk_eq("R4 enable low reloads and freezes", tmo_sts, 0);
        ts(1);
        chk_eq("R4 timeout after enable reload", tmo_sts, 1);
        do_clr();
        do_kick(); ts(2);
        tmo_val = 5'd4; tmo_wr = 1'b1; nxt(); tmo_wr = 1'b0;
        ts(4);
        chk_eq("R4 field write reloads new value", tmo_sts, 0);
        ts(1);
        chk_eq("R4 timeout with new value", tmo_sts, 1);
        do_clr();
    endtask

    task automatic t_stop_and_setwins();
        int n, h;
        wd_rst_en = 1'b1; tmo_val = 5'd0; do_kick();
        ts(1);
        pulse_len(n);
        chk_eq("R6 pulse length on short timeout", n, PLEN);
        do_clr();
        ts(10);
        chk_eq("R8 no second timeout without reload", tmo_sts, 0);
        quiet(5, h);
        chk_eq("R8 no second pulse without reload", h, 0);
        do_kick();
        nxt(); tick_short = 1'b1; sts_clr = 1'b1; nxt(); tick_short = 1'b0; sts_clr = 1'b0;
        chk_eq("R5 set wins over clear", tmo_sts, 1);
        pulse_len(n);
        chk_eq("R8 reload re-arms pulse", n, PLEN);
        do_clr();
    endtask

    task automatic t_fc();
        int n, h;
        wd_rst_en = 1'b0; fc_rst_en = 1'b0;
        do_fc();
        quiet(20, h);
        chk_eq("R7 no pulse when disabled", h, 0);
        fc_rst_en = 1'b1;
        do_fc();
        chk_eq("R7 pulse starts next cycle", rst_pulse, 1);
        pulse_len(n);
        chk_eq("R7 pulse length", n, PLEN);
    endtask

    task automatic t_extend();
        int n;
        do_fc();
        repeat (9) nxt();
        chk_eq("R9 pulse still high", rst_pulse, 1);
        do_fc();
        pulse_len(n);
        chk_eq("R9 pulse restarted to full length", n, PLEN);
    endtask

    task automatic t_both();
        int n, h;
        wd_rst_en = 1'b1; fc_rst_en = 1'b1; tmo_val = 5'd0; do_kick();
        nxt(); tick_short = 1'b1; fc_done = 1'b1; nxt(); tick_short = 1'b0; fc_done = 1'b0;
        chk_eq("R10 status from simultaneous timeout", tmo_sts, 1);
        pulse_len(n);
        chk_eq("R10 single merged pulse", n, PLEN);
        quiet(6, h);
        chk_eq("R10 no trailing pulse", h, 0);
        do_clr();
    endtask

    task automatic t_reload_wins();
        tmo_val = 5'd0; do_kick();
        nxt(); tick_short = 1'b1; kick = 1'b1; nxt(); tick_short = 1'b0; kick = 1'b0;
        chk_eq("R11 reload beats tick", tmo_sts, 0);
        ts(1);
        chk_eq("R11 next tick expires", tmo_sts, 1);
    endtask

    task automatic t_mid_reset();
        rst = 1'b1; nxt(); rst = 1'b0;
        chk_eq("R1 sts cleared by reset", tmo_sts, 0);
        chk_eq("R1 pulse cleared by reset", rst_pulse, 0);
        ts(3);
        chk_eq("R1 counter idle after reset", tmo_sts, 0);
    endtask

    initial begin
        repeat (3) nxt();
        rst = 1'b0;
        nxt();
        t_reset();
        t_short_timeout();
        t_units();
        t_reload();
        t_stop_and_setwins();
        t_fc();
        t_extend();
        t_both();
        t_reload_wins();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule